// File: doc/BRIEF.md
# Crossing-Based Commutation Estimator

This block finds the commutation instants of a four-switch, three-phase brushless motor drive without Hall sensors. A comparator outside the block watches the two controlled phase voltages after filtering. Its single output bit changes level whenever those voltages cross, which happens twice per electrical cycle. The block synchronises that bit and turns each change of level into a crossing event. It measures the number of clock cycles between events. From that measurement it places the two commutations that fall between crossings at one third and two thirds of the measured interval.

The output is a three-bit mode code in Hall-sensor form. A crossing forces the code to a fixed state that depends on the direction of the comparator change. The code then advances one step at each scheduled commutation. If the interval counter hits its ceiling, the block treats this as a stalled rotor and holds the code. Each crossing also starts a reciprocal division that turns the measured interval into a speed value. The constant of that division is chosen so that the result reads directly in rpm, assuming four crossings per revolution.

Top module: `xing_commutation_estimator`

## Requirements
- R1: A change of `cmp_in` in either direction produces a one-cycle pulse on `xing_strobe`. The pulse is high in the cycle after the third rising clock edge that samples the new level.
- R2: In the cycle where `xing_strobe` is high, `mode_out` is 3'b101 if the comparator went high and 3'b010 if it went low.
- R3: The interval counter is cleared to zero by a crossing and increments once per clock. The interval N latched at a crossing is therefore the spacing between that strobe and the previous one, minus one.
- R4: TC1 = floor(N * 21845 / 65536). When TC1 >= 1, the first step of `mode_out` after a crossing is visible in cycle TC1+1, counting the strobe cycle as cycle 0. When TC1 = 0, it is visible in cycle 1.
- R5: TC2 = 2*TC1. When TC1 >= 1, the second step is visible in cycle TC2+1. When TC1 = 0, it is visible in cycle 2. No further step occurs before the next crossing.
- R6: Each step follows the cycle 101, 100, 110, 010, 011, 001, then back to 101. A step never produces 000 or 111.
- R7: The interval counter stops at 2^CNT_W-1 and does not wrap. A crossing that latches this value sets `stall` from its strobe cycle onward. While `stall` is set, `mode_out` changes only at crossings. The next crossing with a smaller interval clears `stall`.
- R8: A crossing cancels any step still pending from the previous interval. The mode goes straight to the crossing code of R2.
- R9: Each crossing starts a division of RPM_K by N that takes ceil(log2(RPM_K+1)) cycles. `speed_valid` pulses for one cycle in the cycle that many cycles after the strobe. At that point `speed_rpm` shows min(floor(RPM_K/N), 2^SPD_W-1), and an N of zero gives the maximum. A new crossing restarts the division.
- R10: After reset, `mode_out` is 3'b101, `stall` is 1, `speed_rpm` is 0, and `xing_strobe` and `speed_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_in | input | 1 | Asynchronous comparator bit from the phase-voltage crossing detector |
| mode_out | output | 3 | Estimated commutation mode in Hall-sensor form |
| xing_strobe | output | 1 | One-cycle pulse for each detected crossing |
| stall | output | 1 | The last latched interval reached the counter ceiling |
| speed_rpm | output | SPD_W | Speed in rpm from the last completed division |
| speed_valid | output | 1 | One-cycle pulse when `speed_rpm` is updated |

## Verification
The assertions that tie a strobe to comparator history take two things for granted. They assume `cmp_in` is low while reset is held. They also assume every level change is held for at least one clock, so that the synchroniser and the comparator history agree. The bench drives `cmp_in` only at falling clock edges, holds it low through reset, and keeps every level for tens of cycles. The shortest interval it uses is eleven cycles. That interval lets the bench check the case where a crossing arrives before the division finishes, while still keeping each level change cleanly separated.

// File: rtl/xce_pkg.sv
// Shared constants and mode helpers for the crossing commutation estimator.
// Assumes Hall-form codes in the order 101,100,110,010,011,001.
package xce_pkg;

    localparam logic [2:0]  MODE_RISE = 3'b101;
    localparam logic [2:0]  MODE_FALL = 3'b010;
    localparam logic [15:0] THIRD_Q16 = 16'd21845;

    // Successor of a mode code in the six-step cycle.
    function automatic logic [2:0] next_mode(input logic [2:0] m);
        case (m)
            3'b101:  return 3'b100;
            3'b100:  return 3'b110;
            3'b110:  return 3'b010;
            3'b010:  return 3'b011;
            3'b011:  return 3'b001;
            3'b001:  return 3'b101;
            default: return MODE_RISE;
        endcase
    endfunction

endpackage

// File: rtl/xce_sync_edge.sv
// Synchroniser and dual-edge detector for the comparator bit.
// Assumes STAGES >= 2; trig is high for one cycle per level change.
module xce_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic trig
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    // Shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    // Keep a delayed copy of the synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign trig  = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/xce_interval_timer.sv
// Saturating interval counter with one-third scaling and stall flag.
// Assumes trig is a one-cycle pulse; cnt restarts from zero after it.
module xce_interval_timer
    import xce_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] tc1,
    output logic [CNT_W:0]   tc2,
    output logic             stall
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam int               PROD_W  = CNT_W + 16;

    logic [PROD_W-1:0] prod;

    // Q16 multiply of the running count by one third.
    always_comb prod = {16'b0, cnt} * {{CNT_W{1'b0}}, THIRD_Q16};

    // Count, latch scaled interval and stall state on each crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            tc1   <= '0;
            stall <= 1'b1;
        end else if (trig) begin
            cnt   <= '0;
            tc1   <= prod[PROD_W-1:16];
            stall <= (cnt == CNT_MAX);
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tc2 = {tc1, 1'b0};
endmodule

// File: rtl/xce_mode_seq.sv
// Mode sequencer: crossing code on trig, then two scheduled steps.
// Assumes tc1/tc2/stall are updated on the same edge as trig.
module xce_mode_seq
    import xce_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             level,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] tc1,
    input  logic [CNT_W:0]   tc2,
    input  logic             stall,
    output logic [2:0]       mode,
    output logic             strobe
);
    typedef enum logic [1:0] {ST_WAIT1, ST_WAIT2, ST_DONE} step_t;
    step_t step;

    // Update mode on crossings and at the scheduled commutation counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= MODE_RISE;
            step   <= ST_DONE;
            strobe <= 1'b0;
        end else begin
            strobe <= trig;
            if (trig) begin
                mode <= level ? MODE_RISE : MODE_FALL;
                step <= ST_WAIT1;
            end else if (!stall) begin
                if (step == ST_WAIT1 && cnt >= tc1) begin
                    mode <= next_mode(mode);
                    step <= ST_WAIT2;
                end else if (step == ST_WAIT2 && {1'b0, cnt} >= tc2) begin
                    mode <= next_mode(mode);
                    step <= ST_DONE;
                end
            end
        end
    end
endmodule

// File: rtl/xce_recip_div.sv
// Restoring divider computing NUM/den, one quotient bit per cycle.
// Assumes start restarts any division in flight; result saturates to OUT_W.
module xce_recip_div #(
    parameter int NUM   = 750000000,
    parameter int DEN_W = 16,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DEN_W-1:0] den,
    output logic [OUT_W-1:0] quo,
    output logic             valid
);
    localparam int           QW    = $clog2(NUM + 1);
    localparam int           IW    = $clog2(QW + 1);
    localparam logic [QW-1:0] NUM_V = QW'(NUM);

    logic [DEN_W:0]   rem, shifted, rem_n;
    logic [QW-1:0]    acc, acc_n;
    logic [DEN_W-1:0] den_q;
    logic [IW-1:0]    iter;
    logic             busy, ge;
    logic [OUT_W-1:0] sat_q;

    // One restoring-division step.
    always_comb begin
        shifted = {rem[DEN_W-1:0], acc[QW-1]};
        ge      = shifted >= {1'b0, den_q};
        rem_n   = ge ? shifted - {1'b0, den_q} : shifted;
        acc_n   = {acc[QW-2:0], ge};
    end

    // Clamp the quotient to the output width.
    generate
        if (QW > OUT_W) begin : g_clamp
            always_comb sat_q = (|acc_n[QW-1:OUT_W] || den_q == '0) ? '1 : acc_n[OUT_W-1:0];
        end else begin : g_wide
            always_comb sat_q = (den_q == '0) ? '1 : OUT_W'(acc_n);
        end
    endgenerate

    // Run the iterations and publish the result with a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            acc   <= '0;
            den_q <= '0;
            iter  <= '0;
            busy  <= 1'b0;
            quo   <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (start) begin
                rem   <= '0;
                acc   <= NUM_V;
                den_q <= den;
                iter  <= IW'(QW);
                busy  <= 1'b1;
            end else if (busy) begin
                rem  <= rem_n;
                acc  <= acc_n;
                iter <= iter - 1'b1;
                if (iter == IW'(1)) begin
                    busy  <= 1'b0;
                    quo   <= sat_q;
                    valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/xing_commutation_estimator.sv
// Top: sensorless commutation estimate from phase-voltage crossings.
// Assumes cmp_in is low during reset and holds each level >= 1 cycle.
module xing_commutation_estimator #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 16,
    parameter int SPD_W       = 16,
    parameter int RPM_K       = 750000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_in,
    output logic [2:0]       mode_out,
    output logic             xing_strobe,
    output logic             stall,
    output logic [SPD_W-1:0] speed_rpm,
    output logic             speed_valid
);
    logic             level, trig;
    logic [CNT_W-1:0] cnt, tc1;
    logic [CNT_W:0]   tc2;

    xce_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(cmp_in), .level(level), .trig(trig)
    );

    xce_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .trig(trig),
        .cnt(cnt), .tc1(tc1), .tc2(tc2), .stall(stall)
    );

    xce_mode_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .trig(trig), .level(level),
        .cnt(cnt), .tc1(tc1), .tc2(tc2), .stall(stall),
        .mode(mode_out), .strobe(xing_strobe)
    );

    xce_recip_div #(.NUM(RPM_K), .DEN_W(CNT_W), .OUT_W(SPD_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(trig), .den(cnt),
        .quo(speed_rpm), .valid(speed_valid)
    );
endmodule

// File: rtl/xce_checker.sv
// Assertion checker for the crossing commutation estimator, bound to the top.
// Assumes cmp_in low in reset and each comparator level held >= 1 cycle.
module xce_checker
    import xce_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmp_in,
    input logic [2:0] mode_out,
    input logic       xing_strobe,
    input logic       stall,
    input logic       speed_valid
);
    logic [1:0] steps_q;
    logic [2:0] mode_prev;

    // Count mode changes since the last crossing strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steps_q   <= '0;
            mode_prev <= MODE_RISE;
        end else begin
            mode_prev <= mode_out;
            if (xing_strobe)                                 steps_q <= '0;
            else if (mode_out != mode_prev && steps_q != 2'd3) steps_q <= steps_q + 1'b1;
        end
    end

    p_strobe_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
        xing_strobe |-> $past(cmp_in, 3) != $past(cmp_in, 4));

    p_strobe_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xing_strobe |-> mode_out == ($past(cmp_in, 3) ? MODE_RISE : MODE_FALL));

    p_two_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        steps_q <= 2'd2);

    p_mode_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_out != 3'b000 && mode_out != 3'b111);

    p_step_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!xing_strobe && mode_out != $past(mode_out)) |-> mode_out == next_mode($past(mode_out)));

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !xing_strobe) |-> $stable(mode_out));

    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        speed_valid |=> !speed_valid);
endmodule

bind xing_commutation_estimator xce_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .mode_out(mode_out),
    .xing_strobe(xing_strobe), .stall(stall), .speed_valid(speed_valid)
);

// File: tb/xing_commutation_estimator_test.sv
// Bench: interval table walked by one loop, then reset and stall corner tests.
module xing_commutation_estimator_test;
    localparam int CNT_W = 10;
    localparam int SPD_W = 16;
    localparam int RPM_K = 1000000;
    localparam int QW    = 20;          // ceil(log2(RPM_K+1))
    localparam int CMAX  = 1023;
    localparam int NV    = 9;
    localparam int VEC_D [NV] = '{60, 60, 90, 45, 11, 60, 300, 40, 60};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmp_in = 1'b0;
    logic [2:0]       mode_out;
    logic             xing_strobe, stall, speed_valid;
    logic [SPD_W-1:0] speed_rpm;
    int               n_chk = 0;
    int               n_fail = 0;
    logic             level = 1'b0;
    logic             done = 1'b0;

    always #10 clk = ~clk;

    xing_commutation_estimator #(.CNT_W(CNT_W), .SPD_W(SPD_W), .RPM_K(RPM_K)) uut (
        .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .mode_out(mode_out),
        .xing_strobe(xing_strobe), .stall(stall),
        .speed_rpm(speed_rpm), .speed_valid(speed_valid)
    );

    function automatic logic [2:0] succ(input logic [2:0] m);
        logic [2:0] ring [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
        for (int k = 0; k < 6; k++) if (ring[k] == m) return ring[(k + 1) % 6];
        return 3'b000;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Toggle the comparator, then follow one interval of d cycles.
    task automatic run_interval(input int d, input bit chk, input int prev_n, input bit exp_stall);
        logic [2:0] code;
        int tc1, j1, j2, spd;
        level  = ~level;
        cmp_in = level;
        code = level ? 3'b101 : 3'b010;
        tc1 = (prev_n * 21845) >> 16;
        j1  = (tc1 == 0) ? 1 : tc1 + 1;
        j2  = (tc1 == 0) ? 2 : 2 * tc1 + 1;
        spd = (prev_n == 0 || RPM_K / prev_n > 65535) ? 65535 : RPM_K / prev_n;
        for (int i = 1; i <= d; i++) begin
            @(negedge clk);
            if (chk && i >= 3 && i - 3 <= d - 3) begin
                automatic int j = i - 3;
                automatic logic [2:0] em = code;
                if (!exp_stall && j >= j1) em = succ(em);
                if (!exp_stall && j >= j2) em = succ(em);
                check("R1 strobe", int'(xing_strobe), int'(j == 0));
                if (j == 0)          check("R2 R8 crossing code", int'(mode_out), int'(em));
                else if (exp_stall)  check("R7 hold", int'(mode_out), int'(em));
                else if (j < j2)     check("R4 R6 first step", int'(mode_out), int'(em));
                else                 check("R5 R6 second step", int'(mode_out), int'(em));
                if (j == 0) check("R7 stall flag", int'(stall), int'(exp_stall));
                if (d >= QW + 3) begin
                    check("R9 valid timing", int'(speed_valid), int'(j == QW));
                    if (j == QW) check("R3 R9 speed", int'(speed_rpm), spd);
                end
            end
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R10: reset state while reset is held and just after release
        check("R10 mode", int'(mode_out), 3'b101);
        check("R10 strobe", int'(xing_strobe), 0);
        check("R10 stall", int'(stall), 1);
        check("R10 speed", int'(speed_rpm), 0);
        check("R10 valid", int'(speed_valid), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check("R7 R10 no steps before first crossing", int'(mode_out), 3'b101);
        // Table walk: each entry is one interval length
        for (int v = 0; v < NV; v++)
            run_interval(VEC_D[v], v != 0, (v == 0) ? 0 : VEC_D[v-1] - 1, 1'b0);
        // R7: hold the comparator so the counter saturates
        repeat (1100) @(negedge clk);
        run_interval(300, 1'b1, CMAX, 1'b1);
        check("R7 stall kept", int'(stall), 1);
        run_interval(60, 1'b1, 299, 1'b0);
        run_interval(60, 1'b1, 59, 1'b0);
        // R10: synchronous reset mid-run
        rst_n = 1'b0;
        cmp_in = 1'b0;
        level = 1'b0;
        @(negedge clk);
        check("R10 mode after reset", int'(mode_out), 3'b101);
        check("R10 stall after reset", int'(stall), 1);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual hung expected done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule